// File: doc/BRIEF.md
# Byte DMA Transfer and Search Engine

This block moves bytes between two ports, A and B, each with its own 16-bit address register. A port can address memory or I/O space, and it can step its address up, step it down or hold it still after each byte. One control bit chooses which port is the source; the other port is the destination. Each byte is read from the source. If copying is enabled the byte is written to the destination. If searching is enabled the byte is compared with a match byte under a mask.

A run ends on a search hit, when the byte counter wraps, or when the counter passes a programmed length limit. In single-byte mode the engine instead stops after each byte, and a later start without reload resumes from where it stopped. When a run ends on a hit or an end of block, the engine can raise an interrupt request. Its vector can carry the cause in bits 2:1. Every memory or I/O access uses a request/ready handshake. A request stays up until a one-cycle ready pulse comes back.

Top module: `bdma_engine`

## Requirements
- R1: When `base_ctl` bit 2 is 1, port A is the source and port B is the destination. When it is 0, the roles are swapped.
- R2: In a port flag byte, bit 3 equal to 1 drives `bus_io` high for that port's accesses (I/O space). Bit 3 equal to 0 keeps `bus_io` low (memory).
- R3: In a port flag byte, bit 5 equal to 1 holds the address fixed. With bit 5 at 0, bit 4 equal to 1 adds one per step and bit 4 equal to 0 subtracts one per step. Both ports step on every step, whichever is the source.
- R4: The first byte after a start with `reload` uses the loaded addresses unchanged. A step happens before every later read, including the read after a resume. After a run of N bytes, each address has therefore stepped N-1 times.
- R5: A destination write happens only when `base_ctl` bit 0 is 1. When it is 0, destination memory is left untouched.
- R6: When `base_ctl` bit 1 is 1, a byte d with ((d XOR `match_byte`) AND NOT `mask_byte`) == 0 sets `match_flag` and stops the engine after that byte.
- R7: `byte_cnt` is cleared by a reload start and adds one per byte. If it wraps to zero, the engine stops and sets `endb_flag`.
- R8: With a nonzero `len_limit` L, the engine stops with `endb_flag` set after the byte that brings the count to L+1. An L of 0 imposes no limit apart from the wrap.
- R9: With `continuous` at 0, one byte is moved per start. A start with `reload` at 0 resumes from the current addresses and count. It is ignored once `match_flag` or `endb_flag` is set.
- R10: When a run stops and `irq_en` is 1, `irq_req` is raised if `irq_flags` bit 0 is set and a hit occurred, or if `irq_flags` bit 1 is set and an end of block occurred. If `irq_flags` bit 5 is 1, `irq_vec` is `irq_base` with bits 2:1 replaced by 01 (hit, which takes priority) or 10 (end of block). Otherwise `irq_vec` equals `irq_base`. `irq_req` stays high until the next accepted start.
- R11: `bus_req` and its address stay stable until `bus_rdy` arrives. `bus_req` is low while the engine is idle. A start while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| reload | input | 1 | With start: load addresses, clear count and flags |
| continuous | input | 1 | 1 = loop until stop, 0 = one byte per start |
| base_ctl | input | 3 | Bit 0 copy, bit 1 search, bit 2 A-is-source |
| flag_a | input | 8 | Port A flags (bit 3 I/O, bit 4 up, bit 5 fixed) |
| flag_b | input | 8 | Port B flags, same layout |
| init_a | input | 16 | Port A start address |
| init_b | input | 16 | Port B start address |
| match_byte | input | 8 | Search pattern |
| mask_byte | input | 8 | Bits set here are ignored in the search |
| len_limit | input | CNT_W | Length limit, 0 = none |
| irq_en | input | 1 | Interrupt enable |
| irq_flags | input | 8 | Bit 0 on hit, bit 1 on end, bit 5 fold status |
| irq_base | input | 8 | Base interrupt vector |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write |
| bus_io | output | 1 | 1 = I/O space |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_rdy |
| bus_rdy | input | 1 | One-cycle completion pulse |
| busy | output | 1 | Engine running |
| addr_a | output | 16 | Current port A address |
| addr_b | output | 16 | Current port B address |
| byte_cnt | output | CNT_W | Bytes handled since reload |
| match_flag | output | 1 | Search hit seen |
| endb_flag | output | 1 | End of block reached |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector |

## Verification
The bench looks for an off-by-one in stepping. A design that stepped before the first read, or after the last one, would end every run one address away from the expected value. The limit test uses a limit of L and expects L+1 bytes, so a comparison that stopped at L bytes shows up as a short count. A hit that lands on the same byte as the limit checks that both flags and the hit-first vector code come out together. A reversed mask polarity would stop the masked search on its first byte. The bench also wraps the counter, resumes in single-byte mode, and pulses start during a run. A design that honoured that pulse would restart and end at the wrong addresses.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
   // base control bit positions
   localparam int CTL_COPY   = 0;
   localparam int CTL_SEARCH = 1;
   localparam int CTL_A_SRC  = 2;
   // port flag bit positions
   localparam int PF_IO      = 3;
   localparam int PF_UP      = 4;
   localparam int PF_FIXED   = 5;
   // interrupt flag bit positions
   localparam int IF_ON_HIT  = 0;
   localparam int IF_ON_END  = 1;
   localparam int IF_FOLD    = 5;
   // folded status codes
   localparam logic [1:0] CODE_HIT = 2'b01;
   localparam logic [1:0] CODE_END = 2'b10;

   typedef enum logic [2:0] {
      S_IDLE,
      S_STEP,
      S_READ,
      S_WRITE,
      S_EVAL
   } eng_state_t;
endpackage

// File: rtl/bdma_port_addr.sv
module bdma_port_addr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] init,
   input  logic              step,
   input  logic              fixed,
   input  logic              up,
   output logic [ADDR_W-1:0] addr
);
   if (ADDR_W < 2) begin : g_bad_w
      $error("bdma_port_addr: ADDR_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= init;
      else if (step && !fixed)
         addr <= up ? addr + 1'b1 : addr - 1'b1;
   end

   p_fixed_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && fixed && !load) |=> $stable(addr));
   p_step_up_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fixed && up && !load) |=> (addr == $past(addr) + 1'b1));
   p_step_down_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !fixed && !up && !load) |=> (addr == $past(addr) - 1'b1));
endmodule

// File: rtl/bdma_match.sv
module bdma_match #(
   parameter int DATA_W = 8
) (
   input  logic              enable,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] pattern,
   input  logic [DATA_W-1:0] ignore,
   output logic              hit
);
   if (DATA_W < 1) begin : g_bad_w
      $error("bdma_match: DATA_W must be positive");
   end

   always_comb hit = enable && (((data ^ pattern) & ~ignore) == '0);
endmodule

// File: rtl/bdma_irq_vec.sv
module bdma_irq_vec #(
   parameter int VEC_W   = 8,
   parameter bit FOLD_EN = 1'b1
) (
   input  logic             enable,
   input  logic [7:0]       cause_sel,
   input  logic [VEC_W-1:0] base,
   input  logic             hit,
   input  logic             at_end,
   output logic             req,
   output logic [VEC_W-1:0] vec
);
   import bdma_pkg::*;

   if (VEC_W < 3) begin : g_bad_w
      $error("bdma_irq_vec: VEC_W must be at least 3");
   end

   logic by_hit, by_end;
   always_comb begin
      by_hit = cause_sel[IF_ON_HIT] && hit;
      by_end = cause_sel[IF_ON_END] && at_end;
      req    = enable && (by_hit || by_end);
   end

   if (FOLD_EN) begin : g_fold
      logic [1:0] code;
      always_comb begin
         code = by_hit ? CODE_HIT : CODE_END;
         if (cause_sel[IF_FOLD])
            vec = {base[VEC_W-1:3], code, base[0]};
         else
            vec = base;
      end
   end else begin : g_plain
      always_comb vec = base;
   end
endmodule

// File: rtl/bdma_engine.sv
module bdma_engine #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16,
   parameter bit FOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              reload,
   input  logic              continuous,
   input  logic [2:0]        base_ctl,
   input  logic [7:0]        flag_a,
   input  logic [7:0]        flag_b,
   input  logic [ADDR_W-1:0] init_a,
   input  logic [ADDR_W-1:0] init_b,
   input  logic [DATA_W-1:0] match_byte,
   input  logic [DATA_W-1:0] mask_byte,
   input  logic [CNT_W-1:0]  len_limit,
   input  logic              irq_en,
   input  logic [7:0]        irq_flags,
   input  logic [7:0]        irq_base,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_io,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_rdy,
   output logic              busy,
   output logic [ADDR_W-1:0] addr_a,
   output logic [ADDR_W-1:0] addr_b,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic              match_flag,
   output logic              endb_flag,
   output logic              irq_req,
   output logic [7:0]        irq_vec
);
   import bdma_pkg::*;

   localparam int NPORT = 2;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("bdma_engine: CNT_W must be at least 2");
   end

   eng_state_t            state;
   logic [2:0]            ctl_q;
   logic [7:0]            fl_q [NPORT];
   logic [DATA_W-1:0]     pat_q, ign_q, data_q;
   logic [CNT_W-1:0]      lim_q;
   logic                  cont_q, ien_q, first_q;
   logic [7:0]            isel_q, ibase_q;

   logic                  accept, do_load, do_step;
   logic [ADDR_W-1:0]     port_addr [NPORT];
   logic [ADDR_W-1:0]     port_init [NPORT];

   always_comb begin
      accept  = start && (state == S_IDLE) &&
                (reload || !(match_flag || endb_flag));
      do_load = accept && reload;
      do_step = (state == S_STEP) && !first_q;
      port_init[0] = init_a;
      port_init[1] = init_b;
   end

   // one address register per port
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      bdma_port_addr #(.ADDR_W(ADDR_W)) u_addr (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (do_load),
         .init  (port_init[p]),
         .step  (do_step),
         .fixed (fl_q[p][PF_FIXED]),
         .up    (fl_q[p][PF_UP]),
         .addr  (port_addr[p])
      );
   end

   assign addr_a = port_addr[0];
   assign addr_b = port_addr[1];

   // role selection
   logic src_i, dst_i;
   always_comb begin
      src_i = ctl_q[CTL_A_SRC] ? 1'b0 : 1'b1;
      dst_i = ~src_i;
   end

   // evaluation of the byte just handled
   logic             hit, wrap, lim_hit, stop, irq_c;
   logic [CNT_W-1:0] cnt_n;
   logic [7:0]       vec_c;

   bdma_match #(.DATA_W(DATA_W)) u_match (
      .enable  (ctl_q[CTL_SEARCH]),
      .data    (data_q),
      .pattern (pat_q),
      .ignore  (ign_q),
      .hit     (hit)
   );

   always_comb begin
      cnt_n   = byte_cnt + 1'b1;
      wrap    = (cnt_n == '0);
      lim_hit = (lim_q != '0) && (byte_cnt >= lim_q);
      stop    = hit || wrap || lim_hit;
   end

   bdma_irq_vec #(.VEC_W(8), .FOLD_EN(FOLD_EN)) u_vec (
      .enable    (ien_q),
      .cause_sel (isel_q),
      .base      (ibase_q),
      .hit       (hit),
      .at_end    (wrap || lim_hit),
      .req       (irq_c),
      .vec       (vec_c)
   );

   // bus drive
   always_comb begin
      bus_req   = (state == S_READ) || (state == S_WRITE);
      bus_we    = (state == S_WRITE);
      bus_addr  = bus_we ? port_addr[dst_i] : port_addr[src_i];
      bus_io    = bus_we ? fl_q[dst_i][PF_IO] : fl_q[src_i][PF_IO];
      bus_wdata = data_q;
      busy      = (state != S_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         ctl_q      <= '0;
         fl_q[0]    <= '0;
         fl_q[1]    <= '0;
         pat_q      <= '0;
         ign_q      <= '0;
         data_q     <= '0;
         lim_q      <= '0;
         cont_q     <= 1'b0;
         ien_q      <= 1'b0;
         isel_q     <= '0;
         ibase_q    <= '0;
         first_q    <= 1'b0;
         byte_cnt   <= '0;
         match_flag <= 1'b0;
         endb_flag  <= 1'b0;
         irq_req    <= 1'b0;
         irq_vec    <= '0;
      end else begin
         unique case (state)
            S_IDLE: if (accept) begin
               ctl_q   <= base_ctl;
               fl_q[0] <= flag_a;
               fl_q[1] <= flag_b;
               pat_q   <= match_byte;
               ign_q   <= mask_byte;
               lim_q   <= len_limit;
               cont_q  <= continuous;
               ien_q   <= irq_en;
               isel_q  <= irq_flags;
               ibase_q <= irq_base;
               irq_req <= 1'b0;
               if (reload) begin
                  first_q    <= 1'b1;
                  byte_cnt   <= '0;
                  match_flag <= 1'b0;
                  endb_flag  <= 1'b0;
               end
               state <= S_STEP;
            end
            S_STEP: begin
               first_q <= 1'b0;
               state   <= S_READ;
            end
            S_READ: if (bus_rdy) begin
               data_q <= bus_rdata;
               state  <= ctl_q[CTL_COPY] ? S_WRITE : S_EVAL;
            end
            S_WRITE: if (bus_rdy) state <= S_EVAL;
            S_EVAL: begin
               byte_cnt <= cnt_n;
               if (hit) match_flag <= 1'b1;
               if (wrap || lim_hit) endb_flag <= 1'b1;
               if (stop && irq_c) begin
                  irq_req <= 1'b1;
                  irq_vec <= vec_c;
               end
               state <= (stop || !cont_q) ? S_IDLE : S_STEP;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   p_req_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
   p_idle_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req);
   p_write_needs_copy_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we) |-> ctl_q[CTL_COPY]);
   p_hit_stops_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag) |-> !busy);
   p_end_stops_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(endb_flag) |-> !busy);
   p_irq_cause_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> (!busy && (match_flag || endb_flag)));
endmodule

// File: tb/sim_bdma_engine.sv
`timescale 1ns/1ps
module sim_bdma_engine;
   localparam int CW = 8;

   typedef struct packed {
      logic [2:0]  ctl;
      logic [7:0]  fa, fb;
      logic [15:0] aa, ab;
      logic [7:0]  mb, mk;
      logic [CW-1:0] lim;
      logic        cont;
      logic [15:0] ea, eb;
      logic [CW-1:0] ecnt;
      logic        em, ee;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{3'b101, 8'h10, 8'h10, 16'h0010, 16'h0080, 8'h00, 8'h00, 8'd3, 1'b1, 16'h0013, 16'h0083, 8'd4, 1'b0, 1'b1},
      '{3'b001, 8'h00, 8'h18, 16'h0090, 16'h0040, 8'h00, 8'h00, 8'd1, 1'b1, 16'h008F, 16'h0041, 8'd2, 1'b0, 1'b1},
      '{3'b110, 8'h10, 8'h20, 16'h0020, 16'h0050, 8'h25, 8'h00, 8'd0, 1'b1, 16'h0025, 16'h0050, 8'd6, 1'b1, 1'b0},
      '{3'b111, 8'h10, 8'h10, 16'h0030, 16'h00A0, 8'h34, 8'h03, 8'd0, 1'b1, 16'h0034, 16'h00A4, 8'd5, 1'b1, 1'b0},
      '{3'b101, 8'h10, 8'h20, 16'h0060, 16'h00C0, 8'h00, 8'h00, 8'd0, 1'b0, 16'h0060, 16'h00C0, 8'd1, 1'b0, 1'b0},
      '{3'b101, 8'h20, 8'h00, 16'h0070, 16'h00D0, 8'h00, 8'h00, 8'd5, 1'b1, 16'h0070, 16'h00CB, 8'd6, 1'b0, 1'b1},
      '{3'b110, 8'h10, 8'h10, 16'h0000, 16'h0000, 8'h02, 8'h00, 8'd2, 1'b1, 16'h0002, 16'h0002, 8'd3, 1'b1, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, reload = 0, continuous = 0, irq_en = 0;
   logic [2:0] base_ctl = '0;
   logic [7:0] flag_a = '0, flag_b = '0, match_byte = '0, mask_byte = '0;
   logic [7:0] irq_flags = '0, irq_base = '0;
   logic [15:0] init_a = '0, init_b = '0;
   logic [CW-1:0] len_limit = '0;
   logic bus_req, bus_we, bus_io, busy, match_flag, endb_flag, irq_req;
   logic [15:0] bus_addr, addr_a, addr_b;
   logic [7:0] bus_wdata, bus_rdata, irq_vec;
   logic [CW-1:0] byte_cnt;
   logic bus_rdy = 1'b0;

   int errors = 0, checks = 0, lat = 0, lat_cnt = 0;
   logic init_req = 1'b0;
   logic io_seen = 1'b0, io_seen_clr = 1'b0;
   logic [7:0] mem [256];
   logic [7:0] io  [256];

   always #2.5 clk = ~clk;

   bdma_engine #(.CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .reload(reload),
      .continuous(continuous), .base_ctl(base_ctl), .flag_a(flag_a),
      .flag_b(flag_b), .init_a(init_a), .init_b(init_b),
      .match_byte(match_byte), .mask_byte(mask_byte), .len_limit(len_limit),
      .irq_en(irq_en), .irq_flags(irq_flags), .irq_base(irq_base),
      .bus_req(bus_req), .bus_we(bus_we), .bus_io(bus_io),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rdy(bus_rdy), .busy(busy), .addr_a(addr_a), .addr_b(addr_b),
      .byte_cnt(byte_cnt), .match_flag(match_flag), .endb_flag(endb_flag),
      .irq_req(irq_req), .irq_vec(irq_vec));

   // memory and I/O model: memory holds its own address, I/O its complement
   assign bus_rdata = bus_io ? io[bus_addr[7:0]] : mem[bus_addr[7:0]];

   always @(posedge clk) begin
      bus_rdy <= 1'b0;
      if (init_req) begin
         for (int i = 0; i < 256; i++) begin
            mem[i] <= 8'(i);
            io[i]  <= ~8'(i);
         end
      end else if (bus_req && !bus_rdy) begin
         if (lat_cnt >= lat) begin
            bus_rdy <= 1'b1;
            lat_cnt <= 0;
            if (bus_we) begin
               if (bus_io) io[bus_addr[7:0]] <= bus_wdata;
               else        mem[bus_addr[7:0]] <= bus_wdata;
            end
         end else lat_cnt <= lat_cnt + 1;
      end
      if (io_seen_clr) io_seen <= 1'b0;
      else if (bus_req && bus_io) io_seen <= 1'b1;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (busy) begin
         errors++; checks++;
         $display("FAIL R11 engine hung actual=busy expected=idle");
      end
   endtask

   task automatic init_mem();
      @(negedge clk); init_req = 1'b1; io_seen_clr = 1'b1;
      @(negedge clk); init_req = 1'b0; io_seen_clr = 1'b0;
   endtask

   task automatic kick(input logic rl);
      start = 1'b1; reload = rl;
      @(negedge clk);
      start = 1'b0; reload = 1'b0;
   endtask

   task automatic run(input vec_t v, input logic ien, input logic [7:0] isel, input logic [7:0] ibase);
      init_mem();
      base_ctl = v.ctl; flag_a = v.fa; flag_b = v.fb;
      init_a = v.aa; init_b = v.ab; match_byte = v.mb; mask_byte = v.mk;
      len_limit = v.lim; continuous = v.cont;
      irq_en = ien; irq_flags = isel; irq_base = ibase;
      kick(1'b1);
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // reset state
      check("R11 reset busy", 32'(busy), 0);
      check("R11 reset req", 32'(bus_req), 0);
      check("R7 reset count", 32'(byte_cnt), 0);
      check("R10 reset irq", 32'(irq_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: roles (R1), io (R2), stepping (R3, R4), search (R6), limit (R8), mode (R9)
      for (int i = 0; i < NV; i++) begin
         lat = i % 3;
         run(VECS[i], 1'b0, 8'h00, 8'h00);
         check($sformatf("R1 R3 R4 vec%0d addr_a", i), 32'(addr_a), 32'(VECS[i].ea));
         check($sformatf("R1 R3 R4 vec%0d addr_b", i), 32'(addr_b), 32'(VECS[i].eb));
         check($sformatf("R7 R8 R9 vec%0d count", i), 32'(byte_cnt), 32'(VECS[i].ecnt));
         check($sformatf("R6 vec%0d match", i), 32'(match_flag), 32'(VECS[i].em));
         check($sformatf("R8 vec%0d end", i), 32'(endb_flag), 32'(VECS[i].ee));
      end

      // R5 copy writes the destination in order
      lat = 1;
      run(VECS[0], 1'b0, 8'h00, 8'h00);
      check("R5 copy first", 32'(mem[8'h80]), 32'h10);
      check("R5 copy last", 32'(mem[8'h83]), 32'h13);
      check("R5 copy beyond", 32'(mem[8'h84]), 32'h84);
      // R9 start without reload after a stop is ignored
      kick(1'b0);
      @(negedge clk);
      check("R9 no resume after end", 32'(busy), 0);
      check("R9 count kept", 32'(byte_cnt), 4);

      // R2 I/O source, memory destination
      run(VECS[1], 1'b0, 8'h00, 8'h00);
      check("R2 io byte at dst", 32'(mem[8'h90]), 32'hBF);
      check("R2 io second byte", 32'(mem[8'h8F]), 32'hBE);
      check("R2 io space used", 32'(io_seen), 1);
      // R2 memory-only run never drives io
      run(VECS[0], 1'b0, 8'h00, 8'h00);
      check("R2 memory only", 32'(io_seen), 0);

      // R5 search only leaves destination untouched
      run(VECS[2], 1'b0, 8'h00, 8'h00);
      check("R5 no write", 32'(mem[8'h50]), 32'h50);

      // R9 single-byte resume steps before the read
      run(VECS[4], 1'b0, 8'h00, 8'h00);
      check("R9 single byte copied", 32'(mem[8'hC0]), 32'h60);
      kick(1'b0);
      wait_idle();
      check("R4 R9 resume addr_a", 32'(addr_a), 32'h61);
      check("R9 resume addr_b fixed", 32'(addr_b), 32'hC0);
      check("R9 resume count", 32'(byte_cnt), 2);
      check("R9 resume byte", 32'(mem[8'hC0]), 32'h61);

      // R7 counter wrap with no limit
      begin
         vec_t w;
         w = VECS[0];
         w.ctl = 3'b100; w.fa = 8'h20; w.fb = 8'h20; w.lim = '0;
         lat = 0;
         run(w, 1'b0, 8'h00, 8'h00);
         check("R7 wrap count", 32'(byte_cnt), 0);
         check("R7 wrap end", 32'(endb_flag), 1);
         check("R7 wrap no match", 32'(match_flag), 0);
      end

      // R11 start while busy is ignored
      begin
         vec_t v0;
         v0 = VECS[0];
         lat = 2;
         init_mem();
         base_ctl = v0.ctl; flag_a = v0.fa; flag_b = v0.fb;
         init_a = v0.aa; init_b = v0.ab; len_limit = v0.lim; continuous = 1'b1;
         irq_en = 1'b0;
         kick(1'b1);
         repeat (4) @(negedge clk);
         init_a = 16'h00E0; init_b = 16'h00F0;
         kick(1'b1);
         wait_idle();
         check("R11 busy start ignored a", 32'(addr_a), 32'h13);
         check("R11 busy start ignored b", 32'(addr_b), 32'h83);
      end

      // R10 interrupt vectors
      lat = 0;
      run(VECS[2], 1'b1, 8'h21, 8'hFF);
      check("R10 hit irq", 32'(irq_req), 1);
      check("R10 hit vector", 32'(irq_vec), 32'hFB);
      run(VECS[0], 1'b1, 8'h22, 8'hFF);
      check("R10 end irq", 32'(irq_req), 1);
      check("R10 end vector", 32'(irq_vec), 32'hFD);
      run(VECS[6], 1'b1, 8'h23, 8'hFF);
      check("R10 hit priority vector", 32'(irq_vec), 32'hFB);
      run(VECS[0], 1'b1, 8'h02, 8'hF9);
      check("R10 unfolded vector", 32'(irq_vec), 32'hF9);
      run(VECS[2], 1'b1, 8'h02, 8'hFF);
      check("R10 hit not selected", 32'(irq_req), 0);
      run(VECS[0], 1'b0, 8'h23, 8'hFF);
      check("R10 irq disabled", 32'(irq_req), 0);
      run(VECS[4], 1'b1, 8'h23, 8'hFF);
      check("R10 no cause no irq", 32'(irq_req), 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule